// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM with Byte Writes

This block is a single-clock synchronous static memory. Each word is 36 bits, split into four 9-bit bytes. Address, write data and control are all sampled on the rising clock edge. The read word comes straight from the memory array in the cycle that follows that edge, with no extra output stage, so a read costs one clock. A write is committed at the same edge that samples it and needs no further cycles.

Three chip-select inputs gate every access: one is active-high and two are active-low. The block is selected only when all three are in their active state. A deselected cycle turns the output drive off at the very next edge. A write can update any subset of the four bytes by combining a byte-write enable with per-byte strobes. A global write strobe stores the whole word and ignores the per-byte controls.

The address is supplied by an external burst sequencer. The shared data bus is split at this boundary into a data-in bus, a data-out bus and an output-enable, which drives the pad tristate.

Top module: `fts_sram`

## Requirements
- R1: While reset is high, and in the cycle after reset, `dout_oe` is 0.
- R2: The block is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A cycle sampled with any of them inactive writes nothing and leaves `dout_oe`=0 in the following cycle.
- R3: A selected cycle is a read when it has `gw_n`=1 and either `bwe_n`=1 or `bw_n`=4'b1111. In the cycle after the sampling edge, a read drives `dout_oe`=1 and puts the stored word at the sampled address on `dout`. A read changes no stored data, whatever `bw_n` holds.
- R4: A selected cycle with `gw_n`=1, `bwe_n`=0 and `bw_n`≠4'b1111 is a byte write. For each byte i with `bw_n[i]`=0, bits [9i+8:9i] take `din[9i+8:9i]`. Bytes with `bw_n[i]`=1 keep their previous value.
- R5: A selected cycle with `gw_n`=0 writes all 36 bits of `din`, whatever `bwe_n` and `bw_n` hold.
- R6: In the cycle after the edge that samples a write, `dout_oe` is 0.
- R7: A word written at one edge is returned by a read of the same address sampled at the very next edge.
- R8: Every address from 0 to 2^ADDR_W−1 is independently addressable, including the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output-enable state |
| addr | input | ADDR_W | Word address from the burst sequencer |
| din | input | 36 | Write data, four 9-bit bytes |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write of all bytes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-byte write strobes, active low, bit i = byte i |
| dout | output | 36 | Read data, valid while dout_oe is 1 |
| dout_oe | output | 1 | Output drive enable for the shared data pad |

## Verification
Random cycles mix reads, global writes and byte writes with arbitrary strobe patterns. Each of the three chip selects is occasionally dropped on its own. A reference array predicts every read word, so a lost or misplaced byte strobe shows up as a corrupted byte, and a write that leaks through a deselected cycle shows up as changed data. Directed cases separate global write from byte write by giving `bwe_n` and `bw_n` values that contradict each other. They also cover the two strobe settings that must still be reads, a read in the cycle right after a write, and the highest address.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

endpackage

// File: rtl/fts_sram_decode.sv
module fts_sram_decode
  import fts_sram_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  output cyc_kind_e         kind,
  output logic [NBYTES-1:0] byte_we
);

  logic              selected;
  logic [NBYTES-1:0] lane_req;

  always_comb begin
    selected = !sel_a_n && sel_b && !sel_c_n;
    // global strobe wins over per-byte controls
    if (!gw_n)       lane_req = '1;
    else if (!bwe_n) lane_req = ~bw_n;
    else             lane_req = '0;
    byte_we = selected ? lane_req : '0;
    if (!selected)        kind = CYC_IDLE;
    else if (|lane_req)   kind = CYC_WRITE;
    else                  kind = CYC_READ;
  end

endmodule

// File: rtl/fts_sram_lane.sv
module fts_sram_lane #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] d,
  output logic [BYTE_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  // single-port, read-first: suits block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= d;
    q <= mem[addr];
  end

endmodule

// File: rtl/fts_sram.sv
module fts_sram
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 9,
  parameter int NBYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BYTE_W*NBYTES-1:0] din,
  input  logic                     sel_a_n,
  input  logic                     sel_b,
  input  logic                     sel_c_n,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [NBYTES-1:0]        bw_n,
  output logic [BYTE_W*NBYTES-1:0] dout,
  output logic                     dout_oe
);

  cyc_kind_e         kind;
  logic [NBYTES-1:0] byte_we;

  fts_sram_decode #(.NBYTES(NBYTES)) u_dec (
    .sel_a_n (sel_a_n),
    .sel_b   (sel_b),
    .sel_c_n (sel_c_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .bw_n    (bw_n),
    .kind    (kind),
    .byte_we (byte_we)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    fts_sram_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lane (
      .clk  (clk),
      .we   (byte_we[i]),
      .addr (addr),
      .d    (din[i*BYTE_W +: BYTE_W]),
      .q    (dout[i*BYTE_W +: BYTE_W])
    );
  end

  // one-edge deselect: the drive state follows the last sampled cycle
  always_ff @(posedge clk) begin
    if (rst) dout_oe <= 1'b0;
    else     dout_oe <= (kind == CYC_READ);
  end

endmodule

// File: rtl/fts_sram_chk.sv
module fts_sram_chk #(
  parameter int NBYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              gw_n,
  input logic              bwe_n,
  input logic [NBYTES-1:0] bw_n,
  input logic [NBYTES-1:0] byte_we,
  input logic              dout_oe
);

  logic sel_now;
  logic wr_now;
  assign sel_now = !sel_a_n && sel_b && !sel_c_n;
  assign wr_now  = !gw_n || (!bwe_n && (bw_n != '1));

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !dout_oe); // R1
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sel_now |=> !dout_oe); // R2
  AST_DESEL_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !sel_now |-> (byte_we == '0)); // R2
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (sel_now && !wr_now) |=> dout_oe); // R3
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    (sel_now && !wr_now) |-> (byte_we == '0)); // R3
  AST_BYTE_MASK: assert property (@(posedge clk) disable iff (rst)
    (sel_now && gw_n && !bwe_n) |-> (byte_we == ~bw_n)); // R4
  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst)
    (sel_now && !gw_n) |-> (byte_we == '1)); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel_now && wr_now) |=> !dout_oe); // R6

endmodule

bind fts_sram fts_sram_chk #(.NBYTES(NBYTES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sel_a_n (sel_a_n),
  .sel_b   (sel_b),
  .sel_c_n (sel_c_n),
  .gw_n    (gw_n),
  .bwe_n   (bwe_n),
  .bw_n    (bw_n),
  .byte_we (byte_we),
  .dout_oe (dout_oe)
);

// File: tb/tb_fts_sram.sv
`timescale 1ns/1ps
module tb_fts_sram;

  localparam int AW = 10;
  localparam int DW = 36;
  localparam logic [AW-1:0] TOP = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [1 << AW];

  always #2.5 clk = ~clk;

  fts_sram dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [3:0] lane_mask(input logic g, input logic b,
                                           input logic [3:0] s);
    if (!g)      return 4'hF;
    else if (!b) return ~s;
    else         return 4'h0;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] d,
                                          input logic [3:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++)
      if (m[i]) r[i*9 +: 9] = d[i*9 +: 9];
    return r;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, sample at the following negedge
  task automatic cyc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic an, input logic b, input logic cn,
                     input logic g, input logic be, input logic [3:0] s,
                     input string tag);
    logic          sel = !an && b && !cn;
    logic [3:0]    m = sel ? lane_mask(g, be, s) : 4'h0;
    logic          rd = sel && (m == 4'h0);
    logic [DW-1:0] rexp = model[a];
    addr = a; din = d; sel_a_n = an; sel_b = b; sel_c_n = cn;
    gw_n = g; bwe_n = be; bw_n = s;
    model[a] = merge(model[a], d, m);
    @(posedge clk);
    @(negedge clk);
    check({tag, " oe"}, {35'd0, dout_oe}, {35'd0, rd});
    if (rd) check({tag, " data"}, dout, rexp);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(a, {DW{1'b1}}, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, tag);
  endtask

  task automatic gwr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input string tag);
    cyc(a, d, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    check("R1 oe in reset", {35'd0, dout_oe}, 36'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 oe after reset", {35'd0, dout_oe}, 36'd0);

    // seed known contents
    for (int i = 0; i < 32; i++) gwr(AW'(i), {4'hA, 32'(i * 32'h01010101)}, "R5 init");
    gwr(TOP, 36'h9_1234_5678, "R8 top write");

    rd(AW'(5), "R5 R7 read after write");
    gwr(AW'(7), 36'h1_2345_6789, "R5");
    rd(AW'(7), "R7 back to back");
    // byte write of lanes 0 and 2
    cyc(AW'(7), 36'hF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1010, "R4 write");
    rd(AW'(7), "R4 merged");
    // global write with contradicting byte controls
    cyc(AW'(8), 36'h5_A5A5_A5A5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, "R5 write");
    rd(AW'(8), "R5 all bytes");
    // strobes low but byte enable off: read, no change
    cyc(AW'(8), 36'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'h0, "R3 bwe off");
    rd(AW'(8), "R3 unchanged");
    // byte enable on but no strobes: read
    cyc(AW'(8), 36'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, "R3 no strobe");
    rd(AW'(8), "R3 unchanged 2");
    // each select dropped alone, with a global write attempt
    cyc(AW'(9), 36'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, "R2 sel_a");
    cyc(AW'(9), 36'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, "R2 sel_b");
    cyc(AW'(9), 36'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, "R2 sel_c");
    rd(AW'(9), "R2 no write when deselected");
    rd(TOP, "R8 top address");
    rd(AW'(0), "R8 bottom address");
    cyc(AW'(3), 36'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, "R2 idle after read");

    for (int k = 0; k < 600; k++) begin
      logic [AW-1:0] a = ($urandom % 9 == 0) ? TOP : AW'($urandom % 32);
      logic [DW-1:0] d = {$urandom, $urandom} & {DW{1'b1}};
      logic an = ($urandom % 10 == 0);
      logic b  = ($urandom % 10 != 0);
      logic cn = ($urandom % 10 == 0);
      logic g  = ($urandom % 6 != 0);
      logic be = $urandom % 2;
      logic [3:0] s = 4'($urandom);
      cyc(a, d, an, b, cn, g, be, s, "R3 R4 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule